// File: doc/BRIEF.md
# First-Word Fall-Through FIFO Controller

This block manages a RAM array as a first-in first-out queue. The write and read ports share one data width. A parameter picks single-clock or dual-clock operation. The controller keeps the write and read addresses itself. It reports four levels: full, empty, almost-full and almost-empty. The two "almost" levels compare the stored word count against thresholds supplied on input ports.

A mode input selects how the read side behaves:

- **Standard mode.** A word is fetched only when the reader asks for it. It appears one read-clock edge after the request.
- **Fall-through mode.** The oldest stored word is moved to the output on its own, with no request. The reader sees it together with a valid flag and takes it by raising the read enable. Once that first word has been taken, later words reach the output the same way, one edge after each take.

Writes into a full array and reads that find nothing to return are dropped. Each sets a sticky error flag that only reset clears.

In dual-clock builds, each pointer crosses into the other domain as Gray code through a synchroniser chain. Full and empty therefore stay asserted a few cycles longer than strictly needed, but never too short.

Top module: `ft_fifo`

## Requirements
- R1: In standard mode, a read enable sampled while `empty` is low removes the oldest word. That word is on `rdData` with `rdValid` high for exactly the one cycle after that read-clock edge. `rdValid` is low after any edge without an accepted read.
- R2: In fall-through mode, with nothing presented, a word written at write edge k is on `rdData` with `rdValid` high after edge k+1, without any read enable. In single-clock builds, `empty` (which means "no word presented" in this mode) goes low at the same time.
- R3: A write enable sampled while `full` is high stores nothing and sets `overflow`. `overflow` then stays high until reset.
- R4: A read enable sampled while nothing is readable changes no stored word and sets `underflow`, which stays high until reset. "Nothing readable" means `empty` high in standard mode and `rdValid` low in fall-through mode.
- R5: `full` is high exactly when the array holds 2^ADDR_W words. In standard mode, `empty` is high exactly when the array holds zero words.
- R6: `almostFull` is high when the number of words in the array is greater than or equal to `afLevel`.
- R7: `almostEmpty` is high when the number of words in the array is less than or equal to `aeLevel`. In fall-through mode, the word already presented on `rdData` is not counted.
- R8: In fall-through mode, a read enable sampled with `rdValid` high consumes the presented word. The next stored word, if any, is presented after that same edge. Without a read enable, `rdData` and `rdValid` hold.
- R9: With DUAL_CLOCK=1 and unrelated write and read clocks, the words come out in the order written. No word is lost or duplicated, and neither error flag is set when the writer respects `full` and the reader respects `rdValid`.
- R10: During and right after reset, the outputs take these values: `empty`=1, `full`=0, `rdValid`=0, `overflow`=0, `underflow`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock (the only clock when DUAL_CLOCK=0) |
| rdClk | input | 1 | Read-side clock; must be tied to wrClk when DUAL_CLOCK=0 |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| wrEn | input | 1 | Write request |
| wrData | input | DATA_W | Word to store |
| rdEn | input | 1 | Read request (standard) or take-presented-word (fall-through) |
| rdData | output | DATA_W | Output word register |
| rdValid | output | 1 | rdData holds a word for the reader |
| fwftMode | input | 1 | 1 = fall-through, 0 = standard; change only during reset |
| afLevel | input | ADDR_W+1 | Almost-full threshold in words |
| aeLevel | input | ADDR_W+1 | Almost-empty threshold in words |
| full | output | 1 | Array holds its full depth (write domain) |
| empty | output | 1 | Nothing readable (read domain) |
| almostFull | output | 1 | Stored count at or above afLevel |
| almostEmpty | output | 1 | Stored count at or below aeLevel |
| overflow | output | 1 | Sticky: a write was refused |
| underflow | output | 1 | Sticky: a read found nothing |

## Verification
The single-clock build is driven in both modes with random traffic at three mixes: write-heavy, which keeps the array near full and probes `full`, `almostFull` and overflow; read-heavy, which keeps it near empty and probes underflow and the presented-word hand-off; and balanced, which exercises simultaneous write and read on one edge. Thresholds are set at the extremes 0 and the full depth as well as mid values, so that off-by-one errors in the compare direction show up. Directed sequences fill past capacity, read an empty queue, and watch the first written word fall through without a read. A dual-clock instance with unrelated clocks streams a counting sequence. Loss, duplication or reordering across the Gray-coded crossing would break the count.

// File: rtl/ft_fifo_pkg.sv
package ft_fifo_pkg;
  // Strobes the control hands to the datapath each cycle.
  typedef struct packed {
    logic wrStb;  // store wrData at the write address
    logic rdStb;  // load the word at the read address into the output register
  } fifoStrobes_t;
endpackage

// File: rtl/ft_fifo_sync.sv
module ft_fifo_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] dIn,
  output logic [W-1:0] dOut
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= '0;
    else       chain[0] <= dIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= '0;
      else       chain[s] <= chain[s-1];
    end
  end

  assign dOut = chain[STAGES-1];
endmodule

// File: rtl/ft_fifo_ctrl.sv
module ft_fifo_ctrl
  import ft_fifo_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter bit DUAL_CLOCK  = 1'b0,
  parameter int SYNC_STAGES = 2,
  localparam int PTR_W      = ADDR_W + 1,
  localparam int DEPTH      = 1 << ADDR_W
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              fwftMode,
  input  logic [PTR_W-1:0]  afLevel,
  input  logic [PTR_W-1:0]  aeLevel,
  output fifoStrobes_t      strobes,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              full,
  output logic              empty,
  output logic              almostFull,
  output logic              almostEmpty,
  output logic              overflow,
  output logic              underflow,
  output logic              rdValid
);
  function automatic logic [PTR_W-1:0] gray2bin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- pointers and crossing ----------------
  logic [PTR_W-1:0] wrPtr, wrGray, wrNext;
  logic [PTR_W-1:0] rdPtr, rdGray, rdNext;
  logic [PTR_W-1:0] wrGrayAtRd, rdGrayAtWr;
  logic [PTR_W-1:0] wrPtrAtRd, rdPtrAtWr;
  logic [PTR_W-1:0] wrCount, rdCount;

  if (DUAL_CLOCK) begin : gCross
    ft_fifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) uRdToWr (
      .clk(wrClk), .rstN(rstN), .dIn(rdGray), .dOut(rdGrayAtWr));
    ft_fifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) uWrToRd (
      .clk(rdClk), .rstN(rstN), .dIn(wrGray), .dOut(wrGrayAtRd));
  end else begin : gDirect
    assign rdGrayAtWr = rdGray;
    assign wrGrayAtRd = wrGray;
  end

  assign rdPtrAtWr = gray2bin(rdGrayAtWr);
  assign wrPtrAtRd = gray2bin(wrGrayAtRd);

  // ---------------- write domain ----------------
  logic push;
  logic fullInt;

  assign wrCount = wrPtr - rdPtrAtWr;
  assign fullInt = (wrCount == PTR_W'(DEPTH));
  assign push    = wrEn && !fullInt;
  assign wrNext  = wrPtr + PTR_W'(push);

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      wrGray   <= '0;
      overflow <= 1'b0;
    end else begin
      wrPtr  <= wrNext;
      wrGray <= wrNext ^ (wrNext >> 1);
      if (wrEn && fullInt) overflow <= 1'b1;
    end
  end

  assign full       = fullInt;
  assign almostFull = (wrCount >= afLevel);
  assign wrAddr     = wrPtr[ADDR_W-1:0];

  // ---------------- read domain ----------------
  logic ramEmpty;
  logic outValid;   // a word sits in the output register (fall-through)
  logic stdValid;   // one-cycle valid pulse (standard)
  logic pop;
  logic consume;
  logic missRead;

  assign rdCount  = wrPtrAtRd - rdPtr;
  assign ramEmpty = (rdCount == '0);
  assign consume  = rdEn && outValid;

  always_comb begin
    if (fwftMode) begin
      pop      = !ramEmpty && (!outValid || rdEn);
      missRead = rdEn && !outValid;
    end else begin
      pop      = rdEn && !ramEmpty;
      missRead = rdEn && ramEmpty;
    end
  end

  assign rdNext = rdPtr + PTR_W'(pop);

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdPtr     <= '0;
      rdGray    <= '0;
      outValid  <= 1'b0;
      stdValid  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      rdPtr    <= rdNext;
      rdGray   <= rdNext ^ (rdNext >> 1);
      stdValid <= !fwftMode && pop;
      if (fwftMode) outValid <= pop || (outValid && !consume);
      else          outValid <= 1'b0;
      if (missRead) underflow <= 1'b1;
    end
  end

  assign rdValid     = fwftMode ? outValid : stdValid;
  assign empty       = fwftMode ? !outValid : ramEmpty;
  assign almostEmpty = (rdCount <= aeLevel);
  assign rdAddr      = rdPtr[ADDR_W-1:0];

  assign strobes.wrStb = push;
  assign strobes.rdStb = pop;
endmodule

// File: rtl/ft_fifo_dpath.sv
module ft_fifo_dpath
  import ft_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  fifoStrobes_t      strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobes.wrStb) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)              rdData <= '0;
    else if (strobes.rdStb) rdData <= mem[rdAddr];
  end
endmodule

// File: rtl/ft_fifo.sv
module ft_fifo
  import ft_fifo_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter bit DUAL_CLOCK  = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  input  logic              fwftMode,
  input  logic [ADDR_W:0]   afLevel,
  input  logic [ADDR_W:0]   aeLevel,
  output logic              full,
  output logic              empty,
  output logic              almostFull,
  output logic              almostEmpty,
  output logic              overflow,
  output logic              underflow
);
  fifoStrobes_t      strobes;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  ft_fifo_ctrl #(
    .ADDR_W(ADDR_W), .DUAL_CLOCK(DUAL_CLOCK), .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEn(wrEn), .rdEn(rdEn), .fwftMode(fwftMode),
    .afLevel(afLevel), .aeLevel(aeLevel),
    .strobes(strobes), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .full(full), .empty(empty), .almostFull(almostFull), .almostEmpty(almostEmpty),
    .overflow(overflow), .underflow(underflow), .rdValid(rdValid)
  );

  ft_fifo_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uDpath (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .strobes(strobes),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: rtl/ft_fifo_chk.sv
module ft_fifo_chk #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 5,
  localparam int DEPTH = 1 << (PTR_W - 1)
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic              fwftMode,
  input logic [PTR_W-1:0]  afLevel,
  input logic              full,
  input logic              empty,
  input logic              almostFull,
  input logic              overflow,
  input logic              underflow,
  input logic              rdValid,
  input logic [DATA_W-1:0] rdData
);
  assert_no_overflow_R3: assert property (@(posedge wrClk) disable iff (!rstN)
    (wrEn && full) |=> overflow);

  assert_overflow_sticky_R3: assert property (@(posedge wrClk) disable iff (!rstN)
    overflow |=> overflow);

  assert_underflow_sticky_R4: assert property (@(posedge rdClk) disable iff (!rstN)
    underflow |=> underflow);

  assert_std_valid_pulse_R1: assert property (@(posedge rdClk) disable iff (!rstN)
    (!fwftMode && !(rdEn && !empty)) |=> !rdValid);

  assert_fwft_hold_R8: assert property (@(posedge rdClk) disable iff (!rstN)
    (fwftMode && rdValid && !rdEn) |=> (rdValid && $stable(rdData)));

  assert_full_implies_af_R6: assert property (@(posedge wrClk) disable iff (!rstN)
    (full && (int'(afLevel) <= DEPTH)) |-> almostFull);
endmodule

bind ft_fifo ft_fifo_chk #(.DATA_W(DATA_W), .PTR_W(ADDR_W + 1)) uChk (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
  .fwftMode(fwftMode), .afLevel(afLevel), .full(full), .empty(empty),
  .almostFull(almostFull), .overflow(overflow), .underflow(underflow),
  .rdValid(rdValid), .rdData(rdData)
);

// File: tb/tb_ft_fifo.sv
module tb_ft_fifo;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int PW = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rclkA = 1'b0;
  always #7 rclkA = ~rclkA;

  // single-clock instance
  logic rstN, wrEn, rdEn, fwftMode;
  logic [DW-1:0] wrData, rdData;
  logic [PW-1:0] afLevel, aeLevel;
  logic rdValid, full, empty, almostFull, almostEmpty, overflow, underflow;

  ft_fifo #(.DATA_W(DW), .ADDR_W(AW), .DUAL_CLOCK(1'b0)) dut (
    .wrClk(clk), .rdClk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .rdValid(rdValid), .fwftMode(fwftMode),
    .afLevel(afLevel), .aeLevel(aeLevel), .full(full), .empty(empty),
    .almostFull(almostFull), .almostEmpty(almostEmpty),
    .overflow(overflow), .underflow(underflow));

  // dual-clock instance
  logic rstAN, wrEnA, rdEnA;
  logic [DW-1:0] wrDataA, rdDataA;
  logic rdValidA, fullA, emptyA, afA, aeA, ovfA, unfA;

  ft_fifo #(.DATA_W(DW), .ADDR_W(AW), .DUAL_CLOCK(1'b1)) dutAsync (
    .wrClk(clk), .rdClk(rclkA), .rstN(rstAN), .wrEn(wrEnA), .wrData(wrDataA),
    .rdEn(rdEnA), .rdData(rdDataA), .rdValid(rdValidA), .fwftMode(1'b1),
    .afLevel(PW'(8)), .aeLevel(PW'(2)), .full(fullA), .empty(emptyA),
    .almostFull(afA), .almostEmpty(aeA), .overflow(ovfA), .underflow(unfA));

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  // reference model state
  int q[$];
  bit mFwft, mOutValid, mStdValid, mOvf, mUnf;
  int mOutData, mAf, mAe;

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit expEmpty();
    return mFwft ? !mOutValid : (q.size() == 0);
  endfunction

  function automatic bit expValid();
    return mFwft ? mOutValid : mStdValid;
  endfunction

  task automatic compareAll();
    chk("R5", "full", full, int'(q.size() == DEPTH));
    chk(mFwft ? "R2" : "R5", "empty", empty, int'(expEmpty()));
    chk("R6", "almostFull", almostFull, int'(q.size() >= mAf));
    chk("R7", "almostEmpty", almostEmpty, int'(q.size() <= mAe));
    chk(mFwft ? "R8" : "R1", "rdValid", rdValid, int'(expValid()));
    if (expValid()) chk(mFwft ? "R8" : "R1", "rdData", rdData, mOutData);
    chk("R3", "overflow", overflow, int'(mOvf));
    chk("R4", "underflow", underflow, int'(mUnf));
  endtask

  // Called at a falling edge: drive, advance the model by one edge, check.
  task automatic cycle(bit we, int wd, bit re);
    bit isFull, ramEmpty, doWr, doRd, pop, cons;
    wrEn = we; wrData = DW'(wd); rdEn = re;
    isFull = (q.size() == DEPTH);
    ramEmpty = (q.size() == 0);
    doWr = we && !isFull;
    if (we && isFull) mOvf = 1'b1;
    if (!mFwft) begin
      doRd = re && !ramEmpty;
      if (re && ramEmpty) mUnf = 1'b1;
      if (doRd) mOutData = q.pop_front();
      mStdValid = doRd;
    end else begin
      cons = re && mOutValid;
      if (re && !mOutValid) mUnf = 1'b1;
      pop = !ramEmpty && (!mOutValid || re);
      if (pop) begin
        mOutData = q.pop_front();
        mOutValid = 1'b1;
      end else if (cons) begin
        mOutValid = 1'b0;
      end
    end
    if (doWr) q.push_back(wd & 8'hFF);
    @(negedge clk);
    compareAll();
  endtask

  task automatic doReset(bit fwft, int af, int ae);
    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0; wrData = '0;
    fwftMode = fwft; afLevel = PW'(af); aeLevel = PW'(ae);
    q.delete();
    mFwft = fwft; mOutValid = 0; mStdValid = 0; mOvf = 0; mUnf = 0;
    mOutData = 0; mAf = af; mAe = ae;
    repeat (2) @(negedge clk);
    chk("R10", "empty in reset", empty, 1);
    chk("R10", "rdValid in reset", rdValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10", "empty", empty, 1);
    chk("R10", "full", full, 0);
    chk("R10", "rdValid", rdValid, 0);
    chk("R10", "overflow", overflow, 0);
    chk("R10", "underflow", underflow, 0);
  endtask

  task automatic randomRun(int n, int wp, int rp);
    for (int i = 0; i < n; i++)
      cycle(($urandom % 100) < wp, $urandom % 256, ($urandom % 100) < rp);
  endtask

  initial begin
    void'($urandom(32'h5EED_0F1F));
    rstAN = 1'b0; wrEnA = 1'b0; rdEnA = 1'b0; wrDataA = '0;

    // ---- standard mode ----
    doReset(1'b0, 12, 3);
    cycle(0, 0, 1);                                  // R4: read while empty
    chk("R4", "underflow after empty read", underflow, 1);
    for (int i = 0; i < DEPTH + 2; i++) cycle(1, 16 + i, 0);  // R3: two refused writes
    chk("R3", "overflow after refused write", overflow, 1);
    chk("R5", "full at depth", full, 1);
    for (int i = 0; i < DEPTH + 1; i++) cycle(0, 0, 1);  // R1: drain in order
    chk("R5", "empty after drain", empty, 1);
    randomRun(150, 80, 20);
    randomRun(150, 20, 80);
    randomRun(150, 50, 50);

    // ---- fall-through mode ----
    doReset(1'b1, 16, 0);
    cycle(1, 8'hA5, 0);
    chk("R2", "not yet presented", rdValid, 0);
    cycle(0, 0, 0);
    chk("R2", "first word presented without read", rdValid, 1);
    chk("R2", "first word value", rdData, 8'hA5);
    cycle(1, 8'h3C, 0);
    cycle(0, 0, 0);
    chk("R8", "word held without read", rdData, 8'hA5);
    cycle(0, 0, 1);
    chk("R8", "next word after take", rdData, 8'h3C);
    cycle(0, 0, 1);
    cycle(0, 0, 1);                                  // R4: take with nothing presented
    chk("R4", "fwft underflow", underflow, 1);
    for (int i = 0; i < DEPTH + 3; i++) cycle(1, 100 + i, 0);
    chk("R3", "fwft overflow", overflow, 1);
    randomRun(150, 20, 80);
    randomRun(150, 80, 20);
    randomRun(150, 50, 50);

    // ---- extreme thresholds, standard mode ----
    doReset(1'b0, 1, 15);
    randomRun(200, 60, 40);
    doReset(1'b0, 0, 16);
    randomRun(60, 50, 50);
    chk("R6", "almostFull with zero level", almostFull, 1);
    chk("R7", "almostEmpty with full-depth level", almostEmpty, 1);

    // ---- dual clock, R9 ----
    repeat (3) @(negedge clk);
    rstAN = 1'b1;
    fork
      begin : writer
        int sent = 0;
        while (sent < 40) begin
          @(negedge clk);
          if (!fullA) begin
            wrEnA = 1'b1; wrDataA = DW'(sent); sent++;
          end else begin
            wrEnA = 1'b0;
          end
          if (($urandom % 4) == 0 && sent > 20) begin
            @(negedge clk); wrEnA = 1'b0;
          end
        end
        @(negedge clk);
        wrEnA = 1'b0;
      end
      begin : reader
        int got = 0;
        int loops = 0;
        while (got < 40 && loops < 6000) begin
          @(negedge rclkA);
          loops++;
          if (rdValidA) begin
            chk("R9", "async word order", rdDataA, got);
            rdEnA = (($urandom % 3) != 0) || (got < 5 && loops > 40);
            if (rdEnA) got++;
          end else begin
            rdEnA = 1'b0;
          end
        end
        @(negedge rclkA);
        rdEnA = 1'b0;
        chk("R9", "async words delivered", got, 40);
      end
    join
    repeat (4) @(negedge rclkA);
    chk("R9", "async overflow", ovfA, 0);
    chk("R9", "async underflow", unfA, 0);
    chk("R9", "async drained", rdValidA, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R9 watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule